// File: doc/BRIEF.md
# Video Crosspoint Routing Core

This block is a digital non-blocking crosspoint for video samples. It has `N_IN` sample inputs and `N_OUT` sample outputs, each `DW` bits wide. Every output keeps its own source selection in a stored route map. A broadcast setting can temporarily send one chosen input to every output without changing that stored map. After the selection, each output has its own overlay strobe. When the strobe is high, an externally supplied overlay sample replaces the routed video. The result then goes through a per-output x1/x2 gain stage, and finally through an output register. That register carries a valid flag, which stands in for a driven or high-impedance output.

Configuration comes in through a one-cycle write strobe with an opcode, an index and an argument. The block resets into standby with every output disabled. Software must set operational mode and the global enable, and must enable each output, before any output is valid. Each output takes one clock cycle to respond to a sample or strobe change. A configuration write takes effect from the cycle after the write.

Top module: `xpt_route`

## Requirements
- R1: After reset every output has valid low and data zero. Reset also leaves the block in standby, with global enable off, every per-output enable and gain cleared, every route map entry at input 0, and broadcast off.
- R2: With opcode 0 (index = output, argument = input number), any output can select any input. Several or all outputs may select the same input at once.
- R3: Opcode 3 (argument = input number) turns broadcast on, and every output then takes that input. While broadcast is on, opcode 0 writes still update the stored map but do not change what is routed.
- R4: Opcode 4 turns broadcast off. Every output then returns to its stored route map entry, including entries written while broadcast was on. Entering or leaving broadcast never changes the map.
- R5: An output is valid only when three things are all 1: its own enable (opcode 1, argument bit 0), the global enable (opcode 5, argument bit 0) and operational mode (opcode 5, argument bit 1). An output that is not valid carries zero data.
- R6: In standby (operational bit 0), every output stays invalid whatever its enable bits are.
- R7: When an output's overlay strobe is high, that output's overlay sample replaces the routed sample before the gain stage.
- R8: When the overlay strobe is low, the routed sample is passed through unchanged.
- R9: Opcode 2 (argument bit 0 set) selects x2 gain for an output. x2 gain shifts the sample left by one bit and saturates at all ones when the top bit is set. Argument bit 0 clear selects x1.
- R10: A change on a sample input or an overlay input appears at the output after exactly one clock edge, and not before.
- R11: A configuration write at one edge affects the output from the following edge on. The output after the write edge itself still reflects the old setting.
- R12: A write with opcode 6 or 7 has no effect on any output or setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Configuration opcode |
| cfg_idx | input | clog2(N_OUT) | Output index for per-output opcodes |
| cfg_arg | input | max(clog2(N_IN),2) | Opcode argument |
| vid_in | input | N_IN*DW | Input samples, input i in bits i*DW upward |
| ovl_strobe | input | N_OUT | Per-output overlay select |
| ovl_data | input | N_OUT*DW | Per-output overlay samples |
| vid_out | output | N_OUT*DW | Registered output samples |
| vid_valid | output | N_OUT | Per-output driven flag |

## Verification
The assertions check several things on every cycle: an invalid output carries zero data, and a valid output had all three enables in the previous cycle. Standby forces every output invalid. An overlaid x1 output equals the previous overlay sample, an x2 output is either even or saturated, and the route map only changes on a route write. Other behaviours need the bench's directed scenarios. These are the choice of source across the whole input/output/gain space, broadcast override and restore, the exact one-edge latency, and opcodes that must be ignored. The bench compares each of them against an arithmetic model.

// File: rtl/xpt_route.sv
module xpt_route #(
  parameter int N_IN  = 32,
  parameter int N_OUT = 32,
  parameter int DW    = 8,
  localparam int SW = $clog2(N_IN),
  localparam int OW = $clog2(N_OUT),
  localparam int AW = (SW > 2) ? SW : 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_op,
  input  logic [OW-1:0]         cfg_idx,
  input  logic [AW-1:0]         cfg_arg,
  input  logic [N_IN*DW-1:0]    vid_in,
  input  logic [N_OUT-1:0]      ovl_strobe,
  input  logic [N_OUT*DW-1:0]   ovl_data,
  output logic [N_OUT*DW-1:0]   vid_out,
  output logic [N_OUT-1:0]      vid_valid
);

  logic [N_OUT-1:0][SW-1:0] map_r;
  logic [N_OUT-1:0]         en_r, gain_r;
  logic                     gen_r, oper_r, bc_on;
  logic [SW-1:0]            bc_sel;
  logic                     idx_ok;

  logic [N_OUT-1:0][DW-1:0] nxt_w;
  logic [N_OUT-1:0]         act_w;
  logic [N_OUT-1:0][DW-1:0] out_r;
  logic [N_OUT-1:0]         val_r;

  assign idx_ok = ({1'b0, cfg_idx} < (OW+1)'(N_OUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_r  <= '0;
      en_r   <= '0;
      gain_r <= '0;
      gen_r  <= 1'b0;
      oper_r <= 1'b0;
      bc_on  <= 1'b0;
      bc_sel <= '0;
    end else if (cfg_we) begin
      case (cfg_op)
        3'd0: if (idx_ok) map_r[cfg_idx]  <= cfg_arg[SW-1:0];
        3'd1: if (idx_ok) en_r[cfg_idx]   <= cfg_arg[0];
        3'd2: if (idx_ok) gain_r[cfg_idx] <= cfg_arg[0];
        3'd3: begin bc_on <= 1'b1; bc_sel <= cfg_arg[SW-1:0]; end
        3'd4: bc_on <= 1'b0;
        3'd5: begin gen_r <= cfg_arg[0]; oper_r <= cfg_arg[1]; end
        default: ;
      endcase
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [SW-1:0] sel;
    logic [DW-1:0] pre;
    logic [DW-1:0] amp;
    assign sel = bc_on ? bc_sel : map_r[o];
    assign pre = ovl_strobe[o] ? ovl_data[o*DW +: DW] : vid_in[sel*DW +: DW];
    assign amp = !gain_r[o] ? pre : (pre[DW-1] ? {DW{1'b1}} : {pre[DW-2:0], 1'b0});
    assign act_w[o] = en_r[o] & gen_r & oper_r;
    assign nxt_w[o] = act_w[o] ? amp : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r <= '0;
      val_r <= '0;
    end else begin
      out_r <= nxt_w;
      val_r <= act_w;
    end
  end

  assign vid_out   = out_r;
  assign vid_valid = val_r;

endmodule

// File: rtl/xpt_route_chk.sv
module xpt_route_chk #(
  parameter int N_IN  = 32,
  parameter int N_OUT = 32,
  parameter int DW    = 8,
  localparam int SW = $clog2(N_IN)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [2:0]               cfg_op,
  input logic [N_OUT-1:0]         ovl_strobe,
  input logic [N_OUT*DW-1:0]      ovl_data,
  input logic [N_OUT-1:0][DW-1:0] out_q,
  input logic [N_OUT-1:0]         val_q,
  input logic [N_OUT-1:0][SW-1:0] map_q,
  input logic [N_OUT-1:0]         en_q,
  input logic [N_OUT-1:0]         gain_q,
  input logic                     gen_q,
  input logic                     oper_q
);

  assert_map_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_op == 3'd0) |=> $stable(map_q));

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !val_q[o] |-> out_q[o] == '0);

    assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      val_q[o] |-> $past(en_q[o] && gen_q && oper_q));

    assert_standby_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!oper_q) |-> !val_q[o]);

    assert_overlay_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q[o] && $past(ovl_strobe[o]) && !$past(gain_q[o]))
        |-> out_q[o] == $past(ovl_data[o*DW +: DW]));

    assert_gain_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q[o] && $past(gain_q[o])) |-> (out_q[o][0] == 1'b0 || out_q[o] == {DW{1'b1}}));
  end

endmodule

bind xpt_route xpt_route_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
  .ovl_strobe(ovl_strobe), .ovl_data(ovl_data),
  .out_q(out_r), .val_q(val_r), .map_q(map_r), .en_q(en_r),
  .gain_q(gain_r), .gen_q(gen_r), .oper_q(oper_r)
);

// File: tb/xpt_route_tb.sv
module xpt_route_tb;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int DW = 4;
  localparam int MX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_op = '0;
  logic [1:0] cfg_idx = '0;
  logic [1:0] cfg_arg = '0;
  logic [NI*DW-1:0] vid_in;
  logic [NO-1:0] ovl_strobe = '0;
  logic [NO*DW-1:0] ovl_data;
  logic [NO*DW-1:0] vid_out;
  logic [NO-1:0] vid_valid;

  logic [DW-1:0] vin [NI];
  logic [DW-1:0] ovd [NO];

  int m_map [NO];
  bit m_en [NO];
  bit m_gain [NO];
  bit m_bc, m_gen, m_op;
  int m_bsel;
  int total = 0;
  int bad = 0;
  logic [NO*DW-1:0] snap_d;
  logic [NO-1:0] snap_v;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NI; i++) vid_in[i*DW +: DW] = vin[i];
    for (int o = 0; o < NO; o++) ovl_data[o*DW +: DW] = ovd[o];
  end

  xpt_route #(.N_IN(NI), .N_OUT(NO), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_idx(cfg_idx), .cfg_arg(cfg_arg), .vid_in(vid_in),
    .ovl_strobe(ovl_strobe), .ovl_data(ovl_data),
    .vid_out(vid_out), .vid_valid(vid_valid)
  );

  function automatic logic [DW:0] expv(int o);
    int s;
    int p;
    s = m_bc ? m_bsel : m_map[o];
    p = ovl_strobe[o] ? int'(ovd[o]) : int'(vin[s]);
    if (m_gain[o]) p = (p * 2 > MX) ? MX : p * 2;
    if (m_en[o] && m_gen && m_op) return {1'b1, DW'(p)};
    return '0;
  endfunction

  task automatic check_all(string req);
    for (int o = 0; o < NO; o++) begin
      logic [DW:0] e, a;
      e = expv(o);
      a = {vid_valid[o], vid_out[o*DW +: DW]};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s out%0d valid/data actual=%h expected=%h", req, o, a, e);
      end
    end
  endtask

  task automatic check_snap(string req);
    total++;
    if (vid_out !== snap_d || vid_valid !== snap_v) begin
      bad++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", req, vid_out, vid_valid, snap_d, snap_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int op, int idx, int arg);
    cfg_we = 1'b1; cfg_op = 3'(op); cfg_idx = 2'(idx); cfg_arg = 2'(arg);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    case (op)
      0: m_map[idx] = arg;
      1: m_en[idx] = arg[0];
      2: m_gain[idx] = arg[0];
      3: begin m_bc = 1; m_bsel = arg; end
      4: m_bc = 0;
      5: begin m_gen = arg[0]; m_op = arg[1]; end
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NI; i++) vin[i] = DW'(i + 1);
    for (int o = 0; o < NO; o++) begin
      ovd[o] = '0; m_map[o] = 0; m_en[o] = 0; m_gain[o] = 0;
    end
    m_bc = 0; m_gen = 0; m_op = 0; m_bsel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    step();
    check_all("R1 after release");

    // R5: bring-up
    wr(5, 0, 3);
    for (int o = 0; o < NO; o++) wr(1, o, 1);
    step();
    check_all("R5 enabled");

    // R2 and R9: sweep every output, source, gain and sample pattern
    for (int o = 0; o < NO; o++)
      for (int s = 0; s < NI; s++)
        for (int g = 0; g < 2; g++) begin
          wr(0, o, s);
          wr(2, o, g);
          for (int v = 0; v <= MX; v++) begin
            for (int j = 0; j < NI; j++) vin[j] = DW'(v + j * 5);
            step();
            check_all("R2 R9 sweep");
          end
        end
    for (int o = 0; o < NO; o++) wr(2, o, 0);

    // R2 fan-out of one input to all outputs
    for (int o = 0; o < NO; o++) wr(0, o, 2);
    step();
    check_all("R2 fan-out");

    // R3 / R4 broadcast override and restore
    for (int o = 0; o < NO; o++) wr(0, o, o);
    for (int j = 0; j < NI; j++) vin[j] = DW'(3 * j + 2);
    wr(3, 1, 1);
    step();
    check_all("R3 broadcast");
    wr(0, 0, 3);
    step();
    check_all("R3 route write during broadcast");
    wr(4, 0, 0);
    step();
    check_all("R4 restore map");

    // R5 gating
    wr(1, 1, 0);
    step();
    check_all("R5 single disable");
    wr(1, 1, 1);
    wr(5, 0, 2);
    step();
    check_all("R5 global off");
    // R6 standby
    wr(5, 0, 1);
    step();
    check_all("R6 standby");
    wr(5, 0, 3);
    step();
    check_all("R6 back to operational");

    // R7 / R8 overlay with mixed gains
    wr(2, 2, 1); wr(2, 3, 1);
    for (int k = 0; k < 16; k++) begin
      ovl_strobe = NO'(k);
      for (int o = 0; o < NO; o++) ovd[o] = DW'(k * 3 + o * 7);
      step();
      check_all("R7 R8 overlay");
    end
    ovl_strobe = '0;
    step();
    check_all("R8 strobe low");

    // R10 latency of a sample change
    snap_d = vid_out; snap_v = vid_valid;
    for (int j = 0; j < NI; j++) vin[j] = vin[j] + DW'(1);
    #1;
    check_snap("R10 no change before edge");
    step();
    check_all("R10 after one edge");
    // R10 latency of a strobe change
    snap_d = vid_out; snap_v = vid_valid;
    ovl_strobe = 4'b0101;
    #1;
    check_snap("R10 strobe before edge");
    step();
    check_all("R10 strobe after edge");
    ovl_strobe = '0;
    step();

    // R11 config takes effect the cycle after the write
    snap_d = vid_out; snap_v = vid_valid;
    wr(0, 0, 1);
    check_snap("R11 write edge");
    step();
    check_all("R11 following edge");
    snap_d = vid_out; snap_v = vid_valid;
    wr(3, 0, 2);
    check_snap("R11 broadcast write edge");
    step();
    check_all("R11 broadcast following edge");
    wr(4, 0, 0);

    // R12 unused opcodes
    wr(6, 0, 3);
    wr(7, 1, 2);
    wr(6, 2, 0);
    step();
    check_all("R12 unused opcodes");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule